// File: doc/BRIEF.md
# Double-Edge Toggle-Gated Up-Counter

This block is an 8-bit synchronous binary up-counter for low-power designs. It advances on both the rising and the falling clock edge, so a clock at half the usual rate gives the same count rate. Each bit stage has two storage elements, one loaded on the rising edge and one on the falling edge. The clock level selects which of the two drives the output.

Each storage element is clocked only when its stored bit differs from the value the counter needs next. Stages that would not toggle receive no clock. A sleep input blocks the clock to every stage. Clock gating is modelled as a per-element load enable. The toggle pattern for the next edge is brought out so that the gating can be observed.

A capture input copies the count into a holding register on a rising edge. There is no streaming data path: every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `tgl_dual_edge_counter`

## Requirements
- R1: While `rst_n` is low, `count` and `held` are 0.
- R2: With `cnt_en`=1, `sleep`=0 and `clr`=0, `count` increases by exactly one at every rising and every falling clock edge.
- R3: The count wraps from 255 to 0 on the edge that follows 255.
- R4: With `cnt_en`=0, `clr`=0 and `sleep`=0, `count` keeps its value across edges and `stage_en` is all zeros.
- R5: With `sleep`=1, `count` keeps its value across edges whatever `clr` and `cnt_en` are, and `stage_en` is all zeros.
- R6: With `clr`=1 and `sleep`=0, `count` becomes 0 at the next edge whatever `cnt_en` is.
- R7: `stage_en[i]` is 1 exactly when bit i of `count` will change at the next edge under the present inputs. Its value is `count` XOR the next count.
- R8: `term` is 1 exactly when `count` is 255 and the next edge will wrap it (`cnt_en`=1, `sleep`=0, `clr`=0).
- R9: When `capture`=1 at a rising edge, `held` takes the `count` value present just before that edge. Otherwise `held` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear; has priority over counting |
| cnt_en | input | 1 | Count enable |
| sleep | input | 1 | Blocks the clock to every stage |
| capture | input | 1 | Loads the holding register on a rising edge |
| count | output | 8 | Present count |
| stage_en | output | 8 | Per-bit toggle pattern for the next edge |
| term | output | 1 | Terminal-count flag |
| held | output | 8 | Holding register contents |

## Verification
The assertions check on every rising edge the properties that hold at a single sampled instant:
- sleep and idle force an all-zero toggle pattern;
- a clear toggles exactly the bits that are set;
- an increment always flips bit 0;
- an ungated element keeps its contents;
- `term` never rises away from 255;
- the holding register loads only on `capture`.

The scoreboard checks the behaviour across both edges: the count stepping twice per clock period, the wrap, a clear issued together with count enable, and `held` capturing the pre-edge value. It compares `count`, `stage_en` and `term` after every edge against a reference counter. This catches elements that go stale when their clock is gated, which no single-edge property can see.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {ACT_HOLD, ACT_INC, ACT_CLR} act_e;

  // Sleep blocks everything, clear beats counting.
  function automatic act_e pick_act(logic sleep, logic clr, logic en);
    if (sleep)    return ACT_HOLD;
    else if (clr) return ACT_CLR;
    else if (en)  return ACT_INC;
    else          return ACT_HOLD;
  endfunction
endpackage

// File: rtl/tdc_step_logic.sv
module tdc_step_logic
  import tdc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pres,
  input  act_e         act,
  output logic [W-1:0] nxt,
  output logic [W-1:0] flip,
  output logic         wrap
);
  always_comb begin
    case (act)
      ACT_INC: nxt = pres + W'(1);
      ACT_CLR: nxt = '0;
      default: nxt = pres;
    endcase
  end

  assign flip = pres ^ nxt;
  assign wrap = (act == ACT_INC) && (&pres);

  // R7
  inc_flips_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_INC) |-> flip[0]);
  // R6
  clr_flips_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLR) |-> (flip == pres));
endmodule

// File: rtl/tdc_bit_stage.sv
module tdc_bit_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_r,
  input  logic ld_f,
  input  logic d_r,
  input  logic d_f,
  output logic q_r,
  output logic q_f
);
  // Rising-phase element; ld_r models the gated clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= 1'b0;
    else if (ld_r) q_r <= d_r;
  end

  // Falling-phase element.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    q_f <= 1'b0;
    else if (ld_f) q_f <= d_f;
  end

  // R7
  rise_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_r |=> $stable(q_r));
endmodule

// File: rtl/tdc_hold_reg.sv
module tdc_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] src,
  output logic [W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= src;
  end

  // R9
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held));
  // R9
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (held == $past(src)));
endmodule

// File: rtl/tgl_dual_edge_counter.sv
module tgl_dual_edge_counter
  import tdc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cnt_en,
  input  logic         sleep,
  input  logic         capture,
  output logic [W-1:0] count,
  output logic [W-1:0] stage_en,
  output logic         term,
  output logic [W-1:0] held
);
  localparam logic [W-1:0] MAX_CNT = '1;

  act_e         act;
  logic [W-1:0] rise_q, fall_q;
  logic [W-1:0] nxt_r, nxt_f, flip_r, flip_f;
  logic         wrap_r, wrap_f;
  logic [W-1:0] ld_r, ld_f;

  assign act = pick_act(sleep, clr, cnt_en);

  // The next rising edge follows the falling element's value, and the reverse.
  tdc_step_logic #(.W(W)) u_step_r (
    .clk(clk), .rst_n(rst_n), .pres(fall_q), .act(act),
    .nxt(nxt_r), .flip(flip_r), .wrap(wrap_r)
  );
  tdc_step_logic #(.W(W)) u_step_f (
    .clk(clk), .rst_n(rst_n), .pres(rise_q), .act(act),
    .nxt(nxt_f), .flip(flip_f), .wrap(wrap_f)
  );

  // An element is clocked only when its own content differs from the target.
  assign ld_r = rise_q ^ nxt_r;
  assign ld_f = fall_q ^ nxt_f;

  for (genvar i = 0; i < W; i++) begin : g_stage
    tdc_bit_stage u_bit (
      .clk(clk), .rst_n(rst_n),
      .ld_r(ld_r[i]), .ld_f(ld_f[i]),
      .d_r(nxt_r[i]), .d_f(nxt_f[i]),
      .q_r(rise_q[i]), .q_f(fall_q[i])
    );
  end

  assign count    = clk ? rise_q : fall_q;
  assign stage_en = clk ? flip_f : flip_r;
  assign term     = clk ? wrap_f : wrap_r;

  tdc_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture), .src(fall_q), .held(held)
  );

  // R5
  sleep_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (stage_en == '0));
  // R4
  idle_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |-> (stage_en == '0));
  // R8
  term_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> (count == MAX_CNT));
endmodule

// File: tb/tgl_dual_edge_counter_tb_top.sv
`timescale 1ns/100ps
module tgl_dual_edge_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, cnt_en = 1'b0, sleep = 1'b0, capture = 1'b0;
  logic [7:0] count, stage_en, held;
  logic       term;

  int    checks = 0, errors = 0;
  string cur_req = "R2";
  logic [7:0] exp_cnt  = 8'd0;
  logic [7:0] exp_held = 8'd0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  tgl_dual_edge_counter dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .sleep(sleep),
    .capture(capture), .count(count), .stage_en(stage_en), .term(term),
    .held(held)
  );

  function automatic logic [7:0] ref_next(logic [7:0] c);
    if (sleep)       return c;
    else if (clr)    return 8'd0;
    else if (cnt_en) return c + 8'd1;
    else             return c;
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver side: reference model pushes the expected count after each edge.
  always @(clk) begin
    if (rst_n) begin
      if (clk && capture) exp_held = exp_cnt;
      exp_cnt = ref_next(exp_cnt);
      exp_q.push_back(exp_cnt);
    end
  end

  // Monitor: pops and compares 1 ns after each edge.
  always @(clk) begin
    if (rst_n) begin
      #1;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual=empty expected=item", cur_req);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check8(cur_req, count, e);
        check8("R7", stage_en, e ^ ref_next(e));
        check8("R8", {7'd0, term},
               {7'd0, (e == 8'hFF) && cnt_en && !sleep && !clr});
        check8("R9", held, exp_held);
      end
    end
  end

  task automatic run(string tag, logic en, logic slp, logic cl, logic cap, int cyc);
    cur_req = tag; cnt_en = en; sleep = slp; clr = cl; capture = cap;
    #(4 * cyc);
  endtask

  initial begin
    fork
      begin
        #1.5;
        check8("R1", count, 8'd0);   // in reset
        check8("R1", held, 8'd0);
        #1.5 rst_n = 1'b1;            // t=3
        #1.5;                          // t=4.5, after a falling edge
        run("R2", 1, 0, 0, 0, 20);
        run("R4", 0, 0, 0, 0, 5);
        run("R2", 1, 0, 0, 1, 1);      // capture while counting (R9)
        run("R3", 1, 0, 0, 0, 120);    // passes through 255 -> 0
        run("R5", 1, 1, 1, 0, 5);
        run("R5", 0, 1, 0, 1, 1);      // capture while asleep (R9)
        run("R6", 1, 0, 1, 0, 3);
        run("R2", 1, 0, 0, 0, 10);
        run("R6", 0, 0, 1, 0, 2);
        run("R2", 1, 0, 0, 0, 130);    // second wrap, term (R8)
        run("R4", 0, 0, 0, 0, 2);
      end
      begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule